// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block sits between a group of peripheral interrupt lines and a CPU. Each maskable source has a small control word holding a mask flag and a three-bit priority level. Software writes and reads these words through a register port. A rising edge on a source line latches a pending flag for that source. The controller picks the best unmasked pending source and offers it to the CPU as one request line plus a source index. One extra non-maskable line outranks every maskable source.

The CPU answers with an acknowledge pulse when it takes the offered request, and with a return pulse when a handler finishes. The controller keeps one in-service bit per priority level, plus one flag for the non-maskable handler. A request that outranks the level now in service interrupts it. A request of equal or lower rank waits. Each return pulse peels off the most urgent level still in service, so suspended handlers resume in order.

Top module: `nest_irq_ctrl`

## Requirements
- R1: After reset every control word reads back as 4'hF (mask set, level 7), no request is offered, and nothing is in service.
- R2: A register write stores reg_wdata into the word selected by reg_addr. Bit 3 is the mask (1 = masked) and bits 2:0 are the level. reg_rdata shows the word at reg_addr in the same cycle.
- R3: A masked source is never offered. Its pending flag is kept, so clearing the mask later offers it.
- R4: A pending flag is set only by a low-to-high transition of its line. It is cleared when that source is acknowledged. A line held high does not set the flag again.
- R5: Among unmasked pending sources, the lowest level number wins. On a tie, the lowest source index wins. The winner's index appears on cpu_src.
- R6: A maskable request is offered only when nothing is in service, or when the winning level is strictly lower in number than the current level.
- R7: An acknowledge of a maskable request marks the winner's level in service, clears that source's pending flag, and makes cur_lvl show the most urgent in-service level.
- R8: A return with no non-maskable handler active clears the most urgent in-service level. The previously suspended level becomes current again.
- R9: A rising edge on nmi_in latches a non-maskable request. It is offered with cpu_req and cpu_nmi both high, ahead of any maskable source and regardless of the in-service levels. Its acknowledge sets nmi_busy.
- R10: While nmi_busy is high, no maskable request is offered. The next return clears nmi_busy and leaves every maskable in-service level unchanged.
- R11: An acknowledge while cpu_req is low changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 16 | Maskable interrupt lines, edge sensitive |
| nmi_in | input | 1 | Non-maskable interrupt line, edge sensitive |
| reg_wr | input | 1 | Control word write strobe |
| reg_addr | input | 4 | Source index for register read and write |
| reg_wdata | input | 4 | Write data {mask, level[2:0]} |
| reg_rdata | output | 4 | Read data {mask, level[2:0]} |
| cpu_ack | input | 1 | CPU takes the offered request |
| cpu_reti | input | 1 | CPU finished the current handler |
| cpu_req | output | 1 | Request offered to the CPU |
| cpu_nmi | output | 1 | Offered request is the non-maskable one |
| cpu_src | output | 4 | Index of the winning maskable source |
| cur_lvl | output | 3 | Most urgent maskable level in service |
| isr_busy | output | 1 | At least one maskable level in service |
| nmi_busy | output | 1 | Non-maskable handler in service |

## Verification
The bench sweeps every pair of current and incoming levels. A strict-versus-equal slip in the comparison would let equal levels nest, or would stop a more urgent level from preempting. A three-deep nest is then unwound to catch a return that clears the wrong level and so restores the wrong handler. Ties among several same-level sources target an arbiter that favours the highest index. A non-maskable handler is run on top of a maskable one, to catch maskable requests that leak through or a return that clears a maskable level instead of the non-maskable flag. Masked-then-unmasked sources, held lines and stray acknowledges check that pending flags are neither lost nor set twice.

// File: rtl/nest_irq_pkg.sv
package nest_irq_pkg;
  localparam int LVL_W = 3;
  localparam int NLVL  = 1 << LVL_W;

  typedef struct packed {
    logic             masked;
    logic [LVL_W-1:0] level;
  } irq_ctrl_t;

  localparam irq_ctrl_t CTRL_RST = '{masked: 1'b1, level: {LVL_W{1'b1}}};
endpackage

// File: rtl/irq_req_latch.sv
module irq_req_latch #(
  parameter int NSRC  = 16,
  localparam int SRC_W = $clog2(NSRC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  irq_in,
  input  logic             clr_en,
  input  logic [SRC_W-1:0] clr_idx,
  output logic [NSRC-1:0]  pend_q
);
  logic [NSRC-1:0] line_q;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    logic rise, hit, pend_en, pend_nx;

    always_comb begin
      rise    = irq_in[g] & ~line_q[g];
      hit     = clr_en && (clr_idx == SRC_W'(g));
      pend_en = rise | hit;
      pend_nx = rise | (pend_q[g] & ~hit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        line_q[g] <= 1'b0;
        pend_q[g] <= 1'b0;
      end else begin
        line_q[g] <= irq_in[g];
        if (pend_en) pend_q[g] <= pend_nx;
      end
    end

    a_r4_set_on_edge_only: assert property (@(posedge clk) disable iff (!rst_n)
      (!pend_q[g] && !(irq_in[g] && !line_q[g])) |=> !pend_q[g]);
  end
endmodule

// File: rtl/irq_prio_arbiter.sv
module irq_prio_arbiter
  import nest_irq_pkg::*;
#(
  parameter int NSRC  = 16,
  localparam int SRC_W = $clog2(NSRC)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NSRC-1:0]      pend,
  input  irq_ctrl_t [NSRC-1:0] ctrl,
  output logic                 best_vld,
  output logic [SRC_W-1:0]     best_idx,
  output logic [LVL_W-1:0]     best_lvl
);
  always_comb begin
    best_vld = 1'b0;
    best_idx = '0;
    best_lvl = '1;
    // scan from the top index down so the lowest index wins a tie
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (pend[i] && !ctrl[i].masked && (!best_vld || ctrl[i].level <= best_lvl)) begin
        best_vld = 1'b1;
        best_idx = SRC_W'(i);
        best_lvl = ctrl[i].level;
      end
    end
  end

  a_r3_winner_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
    best_vld |-> (pend[best_idx] && !ctrl[best_idx].masked));
  a_r5_winner_level: assert property (@(posedge clk) disable iff (!rst_n)
    best_vld |-> (ctrl[best_idx].level == best_lvl));
endmodule

// File: rtl/irq_nest_track.sv
module irq_nest_track
  import nest_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             nmi_in,
  input  logic             ack_nmi,
  input  logic             ack_mask,
  input  logic [LVL_W-1:0] ack_lvl,
  input  logic             reti,
  output logic             nmi_pend,
  output logic             nmi_isr,
  output logic             cur_vld,
  output logic [LVL_W-1:0] cur_lvl
);
  logic [NLVL-1:0] isr_q, isr_nx, isr_low;
  logic            isr_en;
  logic            nmi_line_q, nmi_rise;
  logic            nmi_pend_q, nmi_pend_nx, nmi_pend_en;
  logic            nmi_isr_q, nmi_isr_nx, nmi_isr_en;

  always_comb begin
    nmi_rise    = nmi_in & ~nmi_line_q;
    nmi_pend_en = nmi_rise | ack_nmi;
    nmi_pend_nx = nmi_rise | (nmi_pend_q & ~ack_nmi);
    nmi_isr_en  = ack_nmi | (reti & nmi_isr_q);
    nmi_isr_nx  = ack_nmi;

    isr_low = isr_q & (~isr_q + 1'b1);
    isr_en  = ack_mask | (reti & ~nmi_isr_q);
    isr_nx  = isr_q;
    if (reti && !nmi_isr_q) isr_nx = isr_nx & ~isr_low;
    if (ack_mask)           isr_nx[ack_lvl] = 1'b1;

    cur_vld = |isr_q;
    cur_lvl = '0;
    for (int i = NLVL - 1; i >= 0; i--) begin
      if (isr_q[i]) cur_lvl = LVL_W'(i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nmi_line_q <= 1'b0;
      nmi_pend_q <= 1'b0;
      nmi_isr_q  <= 1'b0;
      isr_q      <= '0;
    end else begin
      nmi_line_q <= nmi_in;
      if (nmi_pend_en) nmi_pend_q <= nmi_pend_nx;
      if (nmi_isr_en)  nmi_isr_q  <= nmi_isr_nx;
      if (isr_en)      isr_q      <= isr_nx;
    end
  end

  assign nmi_pend = nmi_pend_q;
  assign nmi_isr  = nmi_isr_q;

  a_r7_ack_marks_level: assert property (@(posedge clk) disable iff (!rst_n)
    ack_mask |=> isr_q[$past(ack_lvl)]);
  a_r8_reti_drops_one: assert property (@(posedge clk) disable iff (!rst_n)
    (reti && !nmi_isr_q && !ack_mask && (isr_q != '0)) |=>
      ($countones(isr_q) == $countones($past(isr_q)) - 1));
  a_r10_nmi_reti_keeps_levels: assert property (@(posedge clk) disable iff (!rst_n)
    (reti && nmi_isr_q) |=> (!nmi_isr_q && $stable(isr_q)));
endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl
  import nest_irq_pkg::*;
#(
  parameter int NSRC  = 16,
  localparam int SRC_W = $clog2(NSRC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  irq_in,
  input  logic             nmi_in,
  input  logic             reg_wr,
  input  logic [SRC_W-1:0] reg_addr,
  input  logic [LVL_W:0]   reg_wdata,
  output logic [LVL_W:0]   reg_rdata,
  input  logic             cpu_ack,
  input  logic             cpu_reti,
  output logic             cpu_req,
  output logic             cpu_nmi,
  output logic [SRC_W-1:0] cpu_src,
  output logic [LVL_W-1:0] cur_lvl,
  output logic             isr_busy,
  output logic             nmi_busy
);
  logic [1:0]           rst_sync_q;
  logic                 rst_n_s;
  irq_ctrl_t [NSRC-1:0] ctrl_q;
  logic [NSRC-1:0]      pend;
  logic                 best_vld;
  logic [SRC_W-1:0]     best_idx;
  logic [LVL_W-1:0]     best_lvl;
  logic                 nmi_pend, nmi_isr, cur_vld;
  logic                 mask_req, ack_ok, ack_nmi, ack_mask;

  // reset asserts at once, releases after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  for (genvar g = 0; g < NSRC; g++) begin : g_ctrl
    logic wr_en;
    assign wr_en = reg_wr && (reg_addr == SRC_W'(g));
    always_ff @(posedge clk or negedge rst_n_s) begin
      if (!rst_n_s)   ctrl_q[g] <= CTRL_RST;
      else if (wr_en) ctrl_q[g] <= irq_ctrl_t'(reg_wdata);
    end
  end
  assign reg_rdata = ctrl_q[reg_addr];

  irq_req_latch #(.NSRC(NSRC)) u_latch (
    .clk(clk), .rst_n(rst_n_s), .irq_in(irq_in),
    .clr_en(ack_mask), .clr_idx(best_idx), .pend_q(pend)
  );

  irq_prio_arbiter #(.NSRC(NSRC)) u_arb (
    .clk(clk), .rst_n(rst_n_s), .pend(pend), .ctrl(ctrl_q),
    .best_vld(best_vld), .best_idx(best_idx), .best_lvl(best_lvl)
  );

  irq_nest_track u_track (
    .clk(clk), .rst_n(rst_n_s), .nmi_in(nmi_in),
    .ack_nmi(ack_nmi), .ack_mask(ack_mask), .ack_lvl(best_lvl),
    .reti(cpu_reti), .nmi_pend(nmi_pend), .nmi_isr(nmi_isr),
    .cur_vld(cur_vld), .cur_lvl(cur_lvl)
  );

  always_comb begin
    cpu_nmi  = nmi_pend & ~nmi_isr;
    mask_req = ~nmi_isr & best_vld & (~cur_vld | (best_lvl < cur_lvl));
    cpu_req  = cpu_nmi | mask_req;
    ack_ok   = cpu_ack & cpu_req;
    ack_nmi  = ack_ok & cpu_nmi;
    ack_mask = ack_ok & ~cpu_nmi;
  end

  assign cpu_src  = best_idx;
  assign isr_busy = cur_vld;
  assign nmi_busy = nmi_isr;

  a_r3_no_masked_offer: assert property (@(posedge clk) disable iff (!rst_n_s)
    (cpu_req && !cpu_nmi) |-> !ctrl_q[cpu_src].masked);
  a_r6_only_preempting: assert property (@(posedge clk) disable iff (!rst_n_s)
    (cpu_req && !cpu_nmi && isr_busy) |-> (ctrl_q[cpu_src].level < cur_lvl));
  a_r10_nmi_blocks: assert property (@(posedge clk) disable iff (!rst_n_s)
    nmi_busy |-> !(cpu_req && !cpu_nmi));
  a_r11_stray_ack: assert property (@(posedge clk) disable iff (!rst_n_s)
    (cpu_ack && !cpu_req && !cpu_reti) |=>
      ($stable(cur_lvl) && $stable(isr_busy) && $stable(nmi_busy)));
endmodule

// File: tb/nest_irq_ctrl_bench.sv
`timescale 1ns/1ps
module nest_irq_ctrl_bench;
  localparam int NSRC = 16;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] irq_in;
  logic        nmi_in, reg_wr, cpu_ack, cpu_reti;
  logic [3:0]  reg_addr, reg_wdata, reg_rdata, cpu_src;
  logic        cpu_req, cpu_nmi, isr_busy, nmi_busy;
  logic [2:0]  cur_lvl;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  nest_irq_ctrl #(.NSRC(NSRC)) u_nest_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .nmi_in(nmi_in),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .cpu_ack(cpu_ack), .cpu_reti(cpu_reti),
    .cpu_req(cpu_req), .cpu_nmi(cpu_nmi), .cpu_src(cpu_src),
    .cur_lvl(cur_lvl), .isr_busy(isr_busy), .nmi_busy(nmi_busy)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input int idx, input int msk, input int lvl);
    reg_wr = 1'b1; reg_addr = 4'(idx); reg_wdata = {1'(msk), 3'(lvl)};
    step();
    reg_wr = 1'b0;
  endtask

  task automatic pulse(input int idx);
    irq_in[idx] = 1'b1; step(); irq_in[idx] = 1'b0;
  endtask

  task automatic ack();
    cpu_ack = 1'b1; step(); cpu_ack = 1'b0;
  endtask

  task automatic reti();
    cpu_reti = 1'b1; step(); cpu_reti = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; irq_in = '0; nmi_in = 1'b0; reg_wr = 1'b0; reg_addr = '0;
    reg_wdata = '0; cpu_ack = 1'b0; cpu_reti = 1'b0;
    repeat (3) step();
    rst_n = 1'b1;
    repeat (4) step();

    // R1: reset state
    for (int i = 0; i < NSRC; i++) begin
      reg_addr = 4'(i); #1;
      chk("R1 ctrl reset", reg_rdata, 15);
    end
    chk("R1 req", cpu_req, 0);
    chk("R1 busy", isr_busy, 0);
    chk("R1 nmi busy", nmi_busy, 0);

    // R2: register write and readback
    for (int i = 0; i < NSRC; i++) wr(i, i % 2, (i * 3) % 8);
    for (int i = 0; i < NSRC; i++) begin
      reg_addr = 4'(i); #1;
      chk("R2 readback", reg_rdata, (i % 2) * 8 + (i * 3) % 8);
    end
    for (int i = 0; i < NSRC; i++) wr(i, 1, 7);

    // R3: masked source held pending, offered once unmasked
    pulse(5);
    chk("R3 masked no req", cpu_req, 0);
    wr(5, 0, 3);
    chk("R3 unmask req", cpu_req, 1);
    chk("R3 unmask src", cpu_src, 5);
    ack();
    chk("R7 cur lvl", cur_lvl, 3);
    chk("R7 flag cleared", cpu_req, 0);
    reti();
    chk("R8 idle", isr_busy, 0);
    wr(5, 1, 7);

    // R4: held line sets flag once
    wr(7, 0, 4);
    irq_in[7] = 1'b1; step();
    chk("R4 edge req", cpu_req, 1);
    ack(); reti();
    repeat (3) step();
    chk("R4 held no refire", cpu_req, 0);
    irq_in[7] = 1'b0; step();
    chk("R4 fall no req", cpu_req, 0);
    wr(7, 1, 7);

    // R5 R7 R8: each source alone
    for (int i = 0; i < NSRC; i++) begin
      wr(i, 0, i % 8);
      pulse(i);
      chk("R5 single req", cpu_req, 1);
      chk("R5 single src", cpu_src, i);
      ack();
      chk("R7 single lvl", cur_lvl, i % 8);
      chk("R7 single busy", isr_busy, 1);
      reti();
      chk("R8 single idle", isr_busy, 0);
      wr(i, 1, 7);
    end

    // R5 R6: ties and lower level wait their turn
    wr(3, 0, 2); wr(9, 0, 2); wr(12, 0, 2); wr(1, 0, 4);
    irq_in[3] = 1'b1; irq_in[9] = 1'b1; irq_in[12] = 1'b1; irq_in[1] = 1'b1;
    step();
    irq_in = '0;
    chk("R5 tie src", cpu_src, 3);
    ack();
    chk("R6 equal waits", cpu_req, 0);
    reti();
    chk("R5 tie next", cpu_src, 9);
    ack(); reti();
    chk("R5 tie last", cpu_src, 12);
    ack(); reti();
    chk("R5 lower last", cpu_src, 1);
    ack(); reti();
    chk("R5 drained", cpu_req, 0);
    wr(3, 1, 7); wr(9, 1, 7); wr(12, 1, 7); wr(1, 1, 7);

    // R6 R8: every current / incoming level pair
    for (int c = 0; c < 8; c++) begin
      for (int n = 0; n < 8; n++) begin
        wr(2, 0, c); wr(6, 0, n);
        pulse(2); ack();
        pulse(6);
        chk("R6 preempt", cpu_req, (n < c) ? 1 : 0);
        if (n < c) begin
          chk("R6 preempt src", cpu_src, 6);
          ack();
          chk("R7 nested lvl", cur_lvl, n);
          reti();
          chk("R8 resume lvl", cur_lvl, c);
          reti();
        end else begin
          reti();
          chk("R6 pending after reti", cpu_src, 6);
          ack();
          chk("R7 later lvl", cur_lvl, n);
          reti();
        end
        chk("R8 pair idle", isr_busy, 0);
      end
    end
    wr(2, 1, 7); wr(6, 1, 7);

    // R8: three-deep unwind
    wr(10, 0, 6); wr(11, 0, 3); wr(13, 0, 0);
    pulse(10); ack(); pulse(11); ack(); pulse(13); ack();
    chk("R8 deep top", cur_lvl, 0);
    reti(); chk("R8 deep mid", cur_lvl, 3);
    reti(); chk("R8 deep low", cur_lvl, 6);
    reti(); chk("R8 deep idle", isr_busy, 0);
    wr(10, 1, 7); wr(11, 1, 7); wr(13, 1, 7);

    // R9 R10: non-maskable over maskable
    wr(4, 0, 5); wr(8, 0, 0);
    pulse(4); ack();
    nmi_in = 1'b1; step(); nmi_in = 1'b0;
    chk("R9 nmi req", cpu_req, 1);
    chk("R9 nmi flag", cpu_nmi, 1);
    ack();
    chk("R9 nmi busy", nmi_busy, 1);
    pulse(8);
    chk("R10 blocked", cpu_req, 0);
    reti();
    chk("R10 nmi cleared", nmi_busy, 0);
    chk("R10 level kept", cur_lvl, 5);
    chk("R10 unblocked", cpu_req, 1);
    chk("R10 unblocked src", cpu_src, 8);
    ack(); reti();
    chk("R8 back to 5", cur_lvl, 5);
    reti();
    // NMI wins over a pending maskable source while idle
    irq_in[4] = 1'b1; nmi_in = 1'b1; step(); irq_in[4] = 1'b0; nmi_in = 1'b0;
    chk("R9 precedence", cpu_nmi, 1);
    ack();
    chk("R9 busy idle", isr_busy, 0);
    reti();
    chk("R9 maskable after", cpu_src, 4);
    ack(); reti();
    wr(4, 1, 7); wr(8, 1, 7);

    // R11: stray acknowledge
    ack();
    chk("R11 busy", isr_busy, 0);
    chk("R11 nmi", nmi_busy, 0);
    chk("R11 req", cpu_req, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule